// File: doc/BRIEF.md
# Configurable Lookup-Table Fabric

This block is a small combinational reconfigurable fabric. It has a grid of lookup tables with three inputs and two outputs. Bundles of routing channels run between the columns. A row of switch points sits below each row of tables, and a crossbar at the bottom edge feeds a 32-bit output bus. A serial chain loads every configuration bit: the table contents, the table input selects, the switch codes and the crossbar selects. Once a full image is loaded, the primary inputs reach the outputs through combinational logic only. Until then the outputs stay at zero.

Signals move downward, one level per table row. Level 0 is the primary input bus, with one lane per channel of every bundle. With the default sizes (4×4 tables, 4 channels, 5 bundles) that gives 20 lanes. Bundle `g` channel `k` is lane `g*4+k`, and table column `c` sits between bundle `c` (its left) and bundle `c+1` (its right). A switch point only carries a channel to the same channel index in the level below. A signal can change channel index only in the bottom crossbar. Table outputs leave from the bottom edge only, into the switch row directly below the table.

Default chain layout: 912 bits. Table region at offset 0 (28 bits per table). Switch region at offset 448. Crossbar region at offset 688.

Top module: `lut_fabric`

## Requirements
- R1: While rst_ni is low and after it is released, before any load, cfg_done_o is 0 and dout_o is all zeros.
- R2: Each clock edge with cfg_en_i high shifts cfg_bit_i into the chain. The first bit sent ends at chain bit 0. cfg_done_o goes high on the edge that completes the 912th shift and stays high while cfg_en_i is low. While cfg_done_o is low, dout_o is all zeros.
- R3: Table (r,c) owns 28 chain bits starting at (r*4+c)*28. Its first 16 bits are its contents: with address a={in2,in1,in0}, output 0 is bit 2a and output 1 is bit 2a+1.
- R4: Table input j (0..2) has a 4-bit select at table offset 16+4*j. Bits [1:0] give the channel index, bit 2 gives the side (0 = bundle c, 1 = bundle c+1, both taken from the level above the table) and bit 3 is the enable.
- R5: A table input whose enable bit is 0 reads as 0.
- R6: Lane L of level r+1 has a 3-bit code at 448+(r*20+L)*3. Code 1 takes lane L of level r (north). Code 2 takes lane L-4 (west bundle, same channel). Code 3 takes lane L+4 (east bundle, same channel). No code moves a signal to another channel index.
- R7: Code 0, or a west or east code with no neighbouring bundle, drives the lane to 0.
- R8: Codes 4 and 5 take outputs 0 and 1 of the table in row r and column g-1. Codes 6 and 7 take outputs 0 and 1 of the table in row r and column g. Table outputs have no other path into the routing.
- R9: Output bit j has a 7-bit select at 688+7*j: bits [5:0] pick a lane of the last level and bit 6 is the enable. Any lane may go to any output bit. A disabled select, or a lane number of 20 or more, gives 0.
- R10: Asserting cfg_en_i while cfg_done_o is high starts a new load. cfg_done_o is low after that edge, and dout_o stays zero until 912 further shifts have completed.
- R11: Once loaded, dout_o follows din_i with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Shift enable for the configuration chain |
| cfg_bit_i | input | 1 | Serial configuration data |
| cfg_done_o | output | 1 | A complete image is loaded |
| din_i | input | 20 | Primary inputs, one per lane of level 0 |
| dout_o | output | 32 | Fabric output bus |

## Verification
The bench loads a bit-reversal image and a mixed network image. The network image combines a 3-input XOR/AND table with a table that has one disabled input and whose contents invert that input. A design that left disabled inputs floating or pulled them high would drop the constant-one output or suppress the AND term. The network image also routes through west and east switch codes, leaves one lane open, disables one crossbar select and points two others past the last lane. An off-by-one bundle index, a channel swap or a missing range check then shows up as a wrong bit. The load is cut partway through and a finished image is then reloaded, so outputs that leaked before a full load, or a done flag that survived a restart, are caught.

// File: rtl/cfab_pkg.sv
package cfab_pkg;
  localparam int LutIn    = 3;
  localparam int LutOut   = 2;
  localparam int LutWords = 1 << LutIn;
  localparam int LutMemW  = LutWords * LutOut;
  localparam int SwCodeW  = 3;

  typedef enum logic [SwCodeW-1:0] {
    SW_OPEN  = 3'd0,
    SW_NORTH = 3'd1,
    SW_WEST  = 3'd2,
    SW_EAST  = 3'd3,
    SW_LL0   = 3'd4,
    SW_LL1   = 3'd5,
    SW_LR0   = 3'd6,
    SW_LR1   = 3'd7
  } sw_code_e;

  function automatic int ch_w(int ch);
    return (ch > 1) ? $clog2(ch) : 1;
  endfunction

  function automatic int lut_sel_w(int ch);
    return ch_w(ch) + 2;
  endfunction

  function automatic int lut_cfg_w(int ch);
    return LutMemW + LutIn * lut_sel_w(ch);
  endfunction

  function automatic int lane_w(int lanes);
    return $clog2(lanes) + 1;
  endfunction
endpackage

// File: rtl/cfab_cfg_chain.sv
module cfab_cfg_chain #(
  parameter int CFG_W = 912
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             done_o
);
  localparam int CNT_W = $clog2(CFG_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CFG_W);

  logic [CFG_W-1:0] sr_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (en_i) begin
      sr_q  <= {bit_i, sr_q[CFG_W-1:1]};
      // a shift after a complete image restarts the count
      cnt_q <= (cnt_q == CNT_FULL) ? CNT_W'(1) : cnt_q + CNT_W'(1);
    end
  end

  assign cfg_o  = sr_q;
  assign done_o = (cnt_q == CNT_FULL);
endmodule

// File: rtl/cfab_lut.sv
module cfab_lut
  import cfab_pkg::*;
#(
  parameter int CH = 4
) (
  input  logic [CH-1:0]            left_i,
  input  logic [CH-1:0]            right_i,
  input  logic [lut_cfg_w(CH)-1:0] cfg_i,
  output logic [LutOut-1:0]        out_o
);
  localparam int CHW   = ch_w(CH);
  localparam int SEL_W = lut_sel_w(CH);

  logic [LutMemW-1:0] mem;
  logic [LutIn-1:0]   addr;

  assign mem = cfg_i[LutMemW-1:0];

  for (genvar j = 0; j < LutIn; j++) begin : g_in
    logic [SEL_W-1:0] sel;
    logic [CHW-1:0]   ch;
    logic             pick;
    assign sel     = cfg_i[LutMemW + j*SEL_W +: SEL_W];
    assign ch      = sel[CHW-1:0];
    assign pick    = sel[CHW] ? right_i[ch] : left_i[ch];
    assign addr[j] = sel[SEL_W-1] & pick;
  end

  assign out_o = mem[{addr, 1'b0} +: LutOut];
endmodule

// File: rtl/cfab_sw_row.sv
module cfab_sw_row
  import cfab_pkg::*;
#(
  parameter int COLS = 4,
  parameter int CH   = 4
) (
  input  logic [(COLS+1)*CH-1:0]         north_i,
  input  logic [COLS*LutOut-1:0]         lut_i,
  input  logic [(COLS+1)*CH*SwCodeW-1:0] cfg_i,
  output logic [(COLS+1)*CH-1:0]         south_o
);
  localparam int GROUPS = COLS + 1;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    for (genvar k = 0; k < CH; k++) begin : g_ch
      localparam int L = g*CH + k;
      sw_code_e code;
      logic west, east, ll0, ll1, lr0, lr1, lane_v;

      assign code = sw_code_e'(cfg_i[L*SwCodeW +: SwCodeW]);

      if (g > 0) begin : g_has_w
        assign west = north_i[L-CH];
        assign ll0  = lut_i[(g-1)*LutOut];
        assign ll1  = lut_i[(g-1)*LutOut + 1];
      end else begin : g_no_w
        assign west = 1'b0;
        assign ll0  = 1'b0;
        assign ll1  = 1'b0;
      end

      if (g < COLS) begin : g_has_e
        assign east = north_i[L+CH];
        assign lr0  = lut_i[g*LutOut];
        assign lr1  = lut_i[g*LutOut + 1];
      end else begin : g_no_e
        assign east = 1'b0;
        assign lr0  = 1'b0;
        assign lr1  = 1'b0;
      end

      always_comb begin
        case (code)
          SW_NORTH: lane_v = north_i[L];
          SW_WEST:  lane_v = west;
          SW_EAST:  lane_v = east;
          SW_LL0:   lane_v = ll0;
          SW_LL1:   lane_v = ll1;
          SW_LR0:   lane_v = lr0;
          SW_LR1:   lane_v = lr1;
          default:  lane_v = 1'b0;
        endcase
      end

      assign south_o[L] = lane_v;
    end
  end
endmodule

// File: rtl/cfab_out_xbar.sv
module cfab_out_xbar
  import cfab_pkg::*;
#(
  parameter int LANES = 20,
  parameter int OUT_W = 32
) (
  input  logic [LANES-1:0]                   lanes_i,
  input  logic [OUT_W*(lane_w(LANES)+1)-1:0] cfg_i,
  output logic [OUT_W-1:0]                   dout_o
);
  localparam int LANE_W = lane_w(LANES);
  localparam int OSEL_W = LANE_W + 1;
  localparam logic [LANE_W-1:0] LANE_LIM = LANE_W'(LANES);

  for (genvar j = 0; j < OUT_W; j++) begin : g_bit
    logic [OSEL_W-1:0] sel;
    logic [LANE_W-1:0] lane;
    logic              in_rng;
    assign sel       = cfg_i[j*OSEL_W +: OSEL_W];
    assign lane      = sel[LANE_W-1:0];
    assign in_rng    = (lane < LANE_LIM);
    assign dout_o[j] = sel[OSEL_W-1] && in_rng && lanes_i[lane];
  end
endmodule

// File: rtl/lut_fabric.sv
module lut_fabric
  import cfab_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int CH    = 4,
  parameter int OUT_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_en_i,
  input  logic                   cfg_bit_i,
  output logic                   cfg_done_o,
  input  logic [(COLS+1)*CH-1:0] din_i,
  output logic [OUT_W-1:0]       dout_o
);
  localparam int LANES    = (COLS + 1) * CH;
  localparam int LUT_W    = lut_cfg_w(CH);
  localparam int SW_ROW_W = LANES * SwCodeW;
  localparam int OSEL_W   = lane_w(LANES) + 1;
  localparam int SW_BASE  = ROWS * COLS * LUT_W;
  localparam int OUT_BASE = SW_BASE + ROWS * SW_ROW_W;
  localparam int CFG_W    = OUT_BASE + OUT_W * OSEL_W;

  logic [CFG_W-1:0]            cfg;
  logic                        done;
  logic [ROWS:0][LANES-1:0]    lvl;
  logic [OUT_W-1:0]            raw;

  cfab_cfg_chain #(.CFG_W(CFG_W)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cfg_en_i),
    .bit_i  (cfg_bit_i),
    .cfg_o  (cfg),
    .done_o (done)
  );

  assign lvl[0] = din_i;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [COLS*LutOut-1:0] lut_o;

    for (genvar c = 0; c < COLS; c++) begin : g_col
      cfab_lut #(.CH(CH)) u_lut (
        .left_i  (lvl[r][c*CH +: CH]),
        .right_i (lvl[r][(c+1)*CH +: CH]),
        .cfg_i   (cfg[(r*COLS + c)*LUT_W +: LUT_W]),
        .out_o   (lut_o[c*LutOut +: LutOut])
      );
    end

    cfab_sw_row #(.COLS(COLS), .CH(CH)) u_sw (
      .north_i (lvl[r]),
      .lut_i   (lut_o),
      .cfg_i   (cfg[SW_BASE + r*SW_ROW_W +: SW_ROW_W]),
      .south_o (lvl[r+1])
    );
  end

  cfab_out_xbar #(.LANES(LANES), .OUT_W(OUT_W)) u_xbar (
    .lanes_i (lvl[ROWS]),
    .cfg_i   (cfg[OUT_BASE +: OUT_W*OSEL_W]),
    .dout_o  (raw)
  );

  assign cfg_done_o = done;
  assign dout_o     = done ? raw : '0;
endmodule

// File: rtl/lut_fabric_chk.sv
module lut_fabric_chk #(
  parameter int OUT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_en_i,
  input logic             cfg_done_o,
  input logic [OUT_W-1:0] dout_o
);
  // R2
  out_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_done_o |-> (dout_o == '0));

  // R2
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_done_o && !cfg_en_i) |=> cfg_done_o);

  // R2
  done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_done_o) |-> $past(cfg_en_i));

  // R10
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_done_o && cfg_en_i) |=> !cfg_done_o);
endmodule

bind lut_fabric lut_fabric_chk #(.OUT_W(OUT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_en_i   (cfg_en_i),
  .cfg_done_o (cfg_done_o),
  .dout_o     (dout_o)
);

// File: tb/lut_fabric_test.sv
module lut_fabric_test;
  localparam int ROWS = 4, COLS = 4, CH = 4, OUT_W = 32;
  localparam int LANES    = (COLS + 1) * CH;
  localparam int LUT_W    = 28;
  localparam int SW_BASE  = ROWS * COLS * LUT_W;
  localparam int OUT_BASE = SW_BASE + ROWS * LANES * 3;
  localparam int CFG_W    = OUT_BASE + OUT_W * 7;
  localparam int NSTIM    = 8;
  localparam logic [LANES-1:0] STIM [NSTIM] = '{
    20'h00000, 20'hFFFFF, 20'h12345, 20'hA5A5A,
    20'h00013, 20'h00210, 20'h80001, 20'h0F0F0
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_en_i = 1'b0;
  logic cfg_bit_i = 1'b0;
  logic cfg_done_o;
  logic [LANES-1:0] din_i = '0;
  logic [OUT_W-1:0] dout_o;

  logic [CFG_W-1:0] cfg_v;
  int checks = 0;
  int failures = 0;

  always #10 clk_i = ~clk_i;

  lut_fabric uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_en_i(cfg_en_i), .cfg_bit_i(cfg_bit_i),
    .cfg_done_o(cfg_done_o), .din_i(din_i), .dout_o(dout_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_sw(int r, int lane, int code);
    cfg_v[SW_BASE + (r*LANES + lane)*3 +: 3] = 3'(code);
  endtask

  task automatic set_lut_mem(int r, int c, logic [15:0] m);
    cfg_v[(r*COLS + c)*LUT_W +: 16] = m;
  endtask

  task automatic set_lut_in(int r, int c, int j, bit en, bit side, int ch);
    cfg_v[(r*COLS + c)*LUT_W + 16 + 4*j +: 4] = {en, side, 2'(ch)};
  endtask

  task automatic set_out(int j, bit en, int lane);
    cfg_v[OUT_BASE + 7*j +: 7] = {en, 6'(lane)};
  endtask

  task automatic build_rev();
    cfg_v = '0;
    for (int r = 0; r < ROWS; r++)
      for (int l = 0; l < LANES; l++) set_sw(r, l, 1);
    for (int j = 0; j < LANES; j++) set_out(j, 1'b1, LANES - 1 - j);
  endtask

  task automatic build_net();
    logic [15:0] ma, mb;
    cfg_v = '0;
    for (int a = 0; a < 8; a++) begin
      logic [2:0] ad;
      ad = 3'(a);
      ma[2*a]   = ^ad;
      ma[2*a+1] = &ad;
      mb[2*a]   = ad[0] & ad[1] & ~ad[2];
      mb[2*a+1] = ~ad[2];
    end
    set_lut_mem(0, 0, ma);
    set_lut_in(0, 0, 0, 1'b1, 1'b0, 0);
    set_lut_in(0, 0, 1, 1'b1, 1'b0, 1);
    set_lut_in(0, 0, 2, 1'b1, 1'b1, 0);
    set_lut_mem(1, 1, mb);
    set_lut_in(1, 1, 0, 1'b1, 1'b0, 0);
    set_lut_in(1, 1, 1, 1'b1, 1'b1, 1);
    set_lut_in(1, 1, 2, 1'b0, 1'b1, 3);
    for (int r = 0; r < ROWS; r++)
      for (int l = 0; l < LANES; l++) set_sw(r, l, 1);
    set_sw(0, 0, 6);
    set_sw(0, 1, 7);
    set_sw(0, 2, 0);
    set_sw(0, 6, 2);
    set_sw(0, 7, 3);
    set_sw(1, 8, 4);
    set_sw(1, 10, 5);
    set_out(0, 1'b1, 0);
    set_out(1, 1'b1, 1);
    set_out(2, 1'b1, 6);
    set_out(3, 1'b1, 7);
    set_out(4, 1'b0, 0);
    set_out(5, 1'b1, 25);
    set_out(6, 1'b1, 2);
    set_out(7, 1'b1, 63);
    set_out(8, 1'b1, 8);
    set_out(9, 1'b1, 10);
  endtask

  function automatic logic [31:0] exp_rev(logic [LANES-1:0] d);
    logic [31:0] e;
    e = '0;
    for (int j = 0; j < LANES; j++) e[j] = d[LANES-1-j];
    return e;
  endfunction

  function automatic logic [31:0] exp_net(logic [LANES-1:0] d);
    logic [31:0] e;
    e = '0;
    e[0] = d[0] ^ d[1] ^ d[4];
    e[1] = d[0] & d[1] & d[4];
    e[2] = d[2];
    e[3] = d[11];
    e[8] = d[4] & d[9];
    e[9] = 1'b1;
    return e;
  endfunction

  task automatic shift_range(int lo, int hi);
    for (int i = lo; i < hi; i++) begin
      @(negedge clk_i);
      cfg_en_i  = 1'b1;
      cfg_bit_i = cfg_v[i];
    end
    @(negedge clk_i);
    cfg_en_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    din_i = '1;
    repeat (3) @(negedge clk_i);
    chk("R1 done in reset", 32'(cfg_done_o), 32'd0);
    chk("R1 dout in reset", dout_o, 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1 dout after reset", dout_o, 32'd0);

    // partial load: outputs gated
    build_rev();
    shift_range(0, CFG_W/2);
    chk("R2 done mid load", 32'(cfg_done_o), 32'd0);
    chk("R2 dout mid load", dout_o, 32'd0);
    shift_range(CFG_W/2, CFG_W - 1);
    chk("R2 done one bit short", 32'(cfg_done_o), 32'd0);
    shift_range(CFG_W - 1, CFG_W);
    chk("R2 done after full load", 32'(cfg_done_o), 32'd1);
    repeat (5) @(negedge clk_i);
    chk("R2 done held", 32'(cfg_done_o), 32'd1);

    // bit reversal through north passes and the crossbar
    for (int i = 0; i < NSTIM; i++) begin
      din_i = STIM[i];
      #1;
      chk("R9 R6 bit reverse", dout_o, exp_rev(STIM[i]));
    end

    // R11: change inputs without any clock edge
    @(posedge clk_i);
    #2;
    din_i = 20'h00001;
    #1;
    chk("R11 comb path", dout_o, exp_rev(20'h00001));

    // network image
    build_net();
    shift_range(0, CFG_W);
    chk("R2 done after net load", 32'(cfg_done_o), 32'd1);
    for (int i = 0; i < NSTIM; i++) begin
      din_i = STIM[i];
      #1;
      chk("R3 R6 R8 net", dout_o, exp_net(STIM[i]));
    end
    for (int v = 0; v < 8; v++) begin
      logic [LANES-1:0] d;
      d = '0;
      d[0] = v[0]; d[1] = v[1]; d[4] = v[2];
      din_i = d;
      #1;
      chk("R3 xor lut", 32'(dout_o[0]), 32'(v[0] ^ v[1] ^ v[2]));
      chk("R3 and lut", 32'(dout_o[1]), 32'(v[0] & v[1] & v[2]));
    end
    din_i = 20'h00210;
    #1;
    chk("R4 right-side input", 32'(dout_o[8]), 32'd1);
    chk("R5 disabled input reads 0", 32'(dout_o[9]), 32'd1);
    din_i = 20'h00010;
    #1;
    chk("R4 both inputs needed", 32'(dout_o[8]), 32'd0);
    din_i = 20'h00804;
    #1;
    chk("R6 west and east", 32'(dout_o[3:2]), 32'd3);
    din_i = '1;
    #1;
    chk("R7 open switch", 32'(dout_o[6]), 32'd0);
    chk("R9 disabled and out of range", 32'({dout_o[7], dout_o[5], dout_o[4]}), 32'd0);
    chk("R9 unused bits", 32'(dout_o[31:10]), 32'd0);

    // restart while loaded
    build_rev();
    shift_range(0, 10);
    chk("R10 done drops", 32'(cfg_done_o), 32'd0);
    chk("R10 dout zero", dout_o, 32'd0);
    shift_range(10, CFG_W);
    chk("R10 done after reload", 32'(cfg_done_o), 32'd1);
    din_i = 20'h12345;
    #1;
    chk("R10 reloaded image", dout_o, exp_rev(20'h12345));

    // reset while loaded
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1 done on reset", 32'(cfg_done_o), 32'd0);
    chk("R1 dout on reset", dout_o, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule